// File: doc/BRIEF.md
# Masked Multi-Field Alarm Comparator

This block watches the running time-of-day fields of a real-time clock (seconds, minutes, hours, date, month, day of week) and compares them with one or more sets of alarm bytes. Each alarm byte is laid out like its clock byte. Its top bit is an enable that pulls that field into the comparison. A channel's sticky flag sets when every enabled field equals the clock. No year field exists, so the year never takes part in matching.

The clock counter sends a one-cycle advance strobe each time its fields step to a new value. The comparison is evaluated only on that strobe. As a result, one matching time sets the flag once, even if the clock holds that value for many cycles. Each channel has its own enables, its own flag and its own clear input. The clock counter, the register bus and any interrupt pin driver live outside this block.

Top module: `alarm_match_top`

## Requirements
- R1: After reset every alarm flag reads 0.
- R2: Only the low FIELD_W-1 bits of an enabled alarm byte are compared with the same bits of the clock byte. The most significant bit of the clock byte is not compared. Field k occupies bits [8k+7:8k], in this order: k=0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week. Channel c's alarm bytes start at bit 48c.
- R3: An alarm byte whose bit 7 is 0 is left out of the comparison, whatever its value.
- R4: Any subset of fields may be enabled. The flag sets only when all enabled fields match, and a single differing enabled field blocks it.
- R5: A channel with no enabled field never sets its flag.
- R6: The comparison is evaluated only in a cycle where `tick` is 1. A match in that cycle sets the flag at the next clock edge. A match with `tick` at 0 has no effect.
- R7: A set flag stays set until `flag_clr` for that channel is 1. It then reads 0 after the next edge, provided no new match is evaluated in that cycle.
- R8: If a clear and a new match occur in the same cycle, the flag stays set.
- R9: The channels are independent. One channel's enables, matches and clears have no effect on another channel's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe: the clock fields have advanced |
| clk_fields | input | NUM_FIELDS*FIELD_W | Current clock field bytes, field 0 lowest |
| alm_fields | input | NUM_CHAN*NUM_FIELDS*FIELD_W | Alarm bytes for all channels, channel 0 lowest |
| flag_clr | input | NUM_CHAN | Per-channel flag clear |
| alarm_flag | output | NUM_CHAN | Per-channel sticky alarm flag |

## Verification
The bench builds the block with its defaults: two channels, six fields of eight bits, and the clock's top bit ignored. These values exercise channel independence, and they let one enabled field or all six decide a match. Because the clock's top bit is excluded, a test can place a 1 there and show that it does not disturb the compare. Directed sequences cover a match held without a strobe, clears with and without a simultaneous match, and a single mismatching field among six enabled ones.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
   // Fields the comparator knows about, in bus order
   typedef enum logic [2:0] {
      FLD_SEC  = 3'd0,
      FLD_MIN  = 3'd1,
      FLD_HOUR = 3'd2,
      FLD_DATE = 3'd3,
      FLD_MON  = 3'd4,
      FLD_DOW  = 3'd5
   } field_e;

   localparam int unsigned DEF_FIELDS = 6;
   localparam int unsigned DEF_WIDTH  = 8;
   localparam int unsigned DEF_CHAN   = 2;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
   parameter int unsigned FIELD_W        = 8,
   parameter bit          IGNORE_CLK_MSB = 1'b1
) (
   input  logic [FIELD_W-1:0] alm_byte,
   input  logic [FIELD_W-1:0] clk_byte,
   output logic               en,
   output logic               hit
);
   localparam int unsigned VAL_W = FIELD_W - 1;

   initial begin
      assert (FIELD_W >= 2) else $fatal(1, "alarm_field_cmp: FIELD_W must be at least 2");
   end

   logic val_eq;

   assign en = alm_byte[FIELD_W-1];

   generate
      if (IGNORE_CLK_MSB) begin : g_low_only
         assign val_eq = (alm_byte[VAL_W-1:0] == clk_byte[VAL_W-1:0]);
      end else begin : g_strict
         assign val_eq = (alm_byte[VAL_W-1:0] == clk_byte[VAL_W-1:0]) && !clk_byte[FIELD_W-1];
      end
   endgenerate

   // A disabled field never blocks a match
   assign hit = !en || val_eq;
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel #(
   parameter int unsigned NUM_FIELDS     = 6,
   parameter int unsigned FIELD_W        = 8,
   parameter bit          IGNORE_CLK_MSB = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           tick,
   input  logic [NUM_FIELDS*FIELD_W-1:0]  clk_fields,
   input  logic [NUM_FIELDS*FIELD_W-1:0]  alm_fields,
   input  logic                           clr,
   output logic                           flag
);
   initial begin
      assert (NUM_FIELDS >= 1) else $fatal(1, "alarm_channel: NUM_FIELDS must be at least 1");
   end

   logic [NUM_FIELDS-1:0] fld_en;
   logic [NUM_FIELDS-1:0] fld_hit;
   logic                  any_en;
   logic                  all_hit;
   logic                  match_evt;
   logic                  flag_q;

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      alarm_field_cmp #(
         .FIELD_W        (FIELD_W),
         .IGNORE_CLK_MSB (IGNORE_CLK_MSB)
      ) u_cmp (
         .alm_byte (alm_fields[f*FIELD_W +: FIELD_W]),
         .clk_byte (clk_fields[f*FIELD_W +: FIELD_W]),
         .en       (fld_en[f]),
         .hit      (fld_hit[f])
      );
   end

   assign any_en    = |fld_en;
   assign all_hit   = &fld_hit;
   assign match_evt = tick && any_en && all_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= match_evt || (flag_q && !clr);
   end

   assign flag = flag_q;

   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && any_en && all_hit) |=> flag_q);
   // R6
   rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(tick));
   // R5
   no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_en && !flag_q) |=> !flag_q);
   // R7
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);
   // R7
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !tick) |=> !flag_q);
endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
   import alarm_match_pkg::*;
#(
   parameter int unsigned NUM_CHAN       = DEF_CHAN,
   parameter int unsigned NUM_FIELDS     = DEF_FIELDS,
   parameter int unsigned FIELD_W        = DEF_WIDTH,
   parameter bit          IGNORE_CLK_MSB = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    tick,
   input  logic [NUM_FIELDS*FIELD_W-1:0]           clk_fields,
   input  logic [NUM_CHAN*NUM_FIELDS*FIELD_W-1:0]  alm_fields,
   input  logic [NUM_CHAN-1:0]                     flag_clr,
   output logic [NUM_CHAN-1:0]                     alarm_flag
);
   localparam int unsigned CHAN_W = NUM_FIELDS * FIELD_W;

   initial begin
      assert (NUM_CHAN >= 1) else $fatal(1, "alarm_match_top: NUM_CHAN must be at least 1");
   end

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      alarm_channel #(
         .NUM_FIELDS     (NUM_FIELDS),
         .FIELD_W        (FIELD_W),
         .IGNORE_CLK_MSB (IGNORE_CLK_MSB)
      ) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick       (tick),
         .clk_fields (clk_fields),
         .alm_fields (alm_fields[c*CHAN_W +: CHAN_W]),
         .clr        (flag_clr[c]),
         .flag       (alarm_flag[c])
      );
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (alarm_flag == '0));
endmodule

// File: tb/alarm_match_top_bench.sv
module alarm_match_top_bench;
   localparam int NC = 2;
   localparam int NF = 6;
   localparam int FW = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick = 1'b0;
   logic [NF*FW-1:0]  clk_fields = '0;
   logic [NC*NF*FW-1:0] alm_fields = '0;
   logic [NC-1:0]     flag_clr = '0;
   logic [NC-1:0]     alarm_flag;

   int n_checks = 0;
   int n_errs   = 0;

   always #4 clk = ~clk;

   alarm_match_top u_alarm_match_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .clk_fields (clk_fields),
      .alm_fields (alm_fields),
      .flag_clr   (flag_clr),
      .alarm_flag (alarm_flag)
   );

   task automatic check(input string req, input logic [NC-1:0] exp);
      n_checks++;
      if (alarm_flag !== exp) begin
         n_errs++;
         $display("FAIL %s: alarm_flag=%b expected %b", req, alarm_flag, exp);
      end
   endtask

   task automatic set_time(input logic [7:0] s, mi, h, d, mo, w);
      clk_fields = {w, mo, d, h, mi, s};
   endtask

   task automatic set_alm(input int ch, input int fld, input logic [7:0] v);
      alm_fields[(ch*NF + fld)*FW +: FW] = v;
   endtask

   // One cycle with optional strobe and clears; returns at the next negedge
   task automatic step(input logic t, input logic [NC-1:0] clr);
      tick = t;
      flag_clr = clr;
      @(negedge clk);
      tick = 1'b0;
      flag_clr = '0;
   endtask

   task automatic clear_all();
      alm_fields = '0;
      step(1'b0, '1);
   endtask

   task automatic t_reset();
      check("R1 reset", 2'b00);
   endtask

   task automatic t_no_enable();
      set_time(8'h10, 8'h20, 8'h03, 8'h04, 8'h05, 8'h06);
      set_alm(0, 0, 8'h10); set_alm(0, 1, 8'h20); set_alm(1, 2, 8'h03);
      step(1'b1, '0);
      check("R5 no enabled field", 2'b00);
      step(1'b1, '0);
      check("R5 repeat strobe", 2'b00);
      clear_all();
   endtask

   task automatic t_single_field();
      set_time(8'h30, 8'h11, 8'h12, 8'h13, 8'h01, 8'h02);
      set_alm(0, 0, 8'h80 | 8'h30);
      set_alm(0, 1, 8'h55);            // disabled, differs
      set_alm(1, 0, 8'h80 | 8'h31);    // channel 1 enabled, no match
      step(1'b1, '0);
      check("R3/R9 seconds only on ch0", 2'b01);
      set_time(8'h31, 8'h11, 8'h12, 8'h13, 8'h01, 8'h02);
      step(1'b1, '0);
      check("R7/R9 ch0 sticky, ch1 sets", 2'b11);
      step(1'b0, 2'b01);
      check("R7/R9 clear ch0 only", 2'b10);
      step(1'b0, 2'b10);
      check("R7 clear ch1", 2'b00);
      clear_all();
   endtask

   task automatic t_no_tick();
      set_time(8'h45, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      set_alm(0, 0, 8'hC5);
      for (int i = 0; i < 4; i++) step(1'b0, '0);
      check("R6 match without strobe", 2'b00);
      step(1'b1, '0);
      check("R6 match with strobe", 2'b01);
      step(1'b0, '0);
      check("R7 held after strobe", 2'b01);
      step(1'b1, 2'b01);
      check("R8 clear with match keeps flag", 2'b01);
      step(1'b0, 2'b01);
      check("R7 clear without match", 2'b00);
      clear_all();
   endtask

   task automatic t_all_fields();
      set_time(8'h59, 8'h58, 8'h23, 8'h31, 8'h12, 8'h06);
      set_alm(1, 0, 8'hD9); set_alm(1, 1, 8'hD8); set_alm(1, 2, 8'hA3);
      set_alm(1, 3, 8'hB1); set_alm(1, 4, 8'h92); set_alm(1, 5, 8'h87);
      step(1'b1, '0);
      check("R4 one of six differs", 2'b00);
      set_alm(1, 5, 8'h86);
      step(1'b1, '0);
      check("R4 all six match", 2'b10);
      clear_all();
   endtask

   task automatic t_msb_ignored();
      set_time(8'h95, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      set_alm(0, 0, 8'h95);
      step(1'b1, '0);
      check("R2 clock MSB ignored", 2'b01);
      step(1'b0, 2'b01);
      set_time(8'h14, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      step(1'b1, '0);
      check("R2 low bits differ", 2'b00);
      clear_all();
   endtask

   initial begin : watchdog
      #800000;
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_enable();
      t_single_field();
      t_no_tick();
      t_all_fields();
      t_msb_ignored();
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule